// File: doc/BRIEF.md
# Task-Segmented Memory Mapping Unit

This block sits between a 16-bit CPU and a 24-bit system bus. It keeps a translation table for sixteen tasks, each with sixteen 4 KB segments. A table entry gives the 12-bit physical page and the access rights for one task's segment. The CPU address bits 15:12 pick the segment, and the currently running task picks which sixteen entries apply. The physical page replaces those four bits, so the supervisor can place any segment anywhere in the 16 MB bus space. It can also drive every bus address line high or low.

Task 0 is the supervisor, and it is the only task that may change the table or the running task. A change of task is not immediate. Writing the task register arms a countdown of opcode fetches. The supervisor keeps running for seven more fetches, which gives its hand-over code time to jump into the new task's space. The eighth fetch is then translated with the new task's entries. Each access is checked against the entry's rights. A denied write never reaches the bus, and a denied access raises a violation flag for one cycle.

Top module: `taskmap_mmu`

## Requirements
- R1: After a synchronous reset, the running task is 0 and the violation flag is low. For tasks 0 and 1, segment s maps to page s. For every other task n, segment s maps to page n*16+s. Every entry starts with read and write rights.
- R2: `bus_addr` is `{page, cpu_addr[11:0]}`. The page comes from the entry at index `{running task, cpu_addr[15:12]}`. The output is combinational from the address and the registered task.
- R3: A pulse on `map_we` while the running task is 0 writes entry `map_idx`, and the new value is used from the next cycle on. The page is `map_data[11:0]`, the read right is bit 12 and the write right is bit 13; bits 15:14 are ignored.
- R4: `bus_wr` follows `cpu_wr` only when the current entry has the write right; otherwise it stays low.
- R5: `viol` is high for exactly the cycle after a cycle that had `cpu_rd` without the read right, or `cpu_wr` without the write right. Otherwise it is low.
- R6: A `task_we` pulse while the running task is 0 arms the switch to `task_data`. The running task changes at the clock edge that ends the seventh cycle with `cpu_m1` high after that pulse. The eighth such fetch is therefore translated in the new task. Cycles without `cpu_m1` are not counted.
- R7: A second `task_we` pulse while a switch is pending replaces the target task and restarts the count from zero.
- R8: While the running task is not 0, `map_we` and `task_we` have no effect.
- R9: A cycle with `cpu_m1` high that also carries an accepted `task_we` is not counted toward the seven fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_we | input | 1 | Table write strobe |
| map_idx | input | 8 | Entry index: task in 7:4, segment in 3:0 |
| map_data | input | 16 | Page in 11:0, read right 12, write right 13 |
| task_we | input | 1 | Task register write strobe |
| task_data | input | 4 | Task to switch to |
| cpu_addr | input | 16 | CPU logical address |
| cpu_rd | input | 1 | CPU read (including fetches) |
| cpu_wr | input | 1 | CPU write |
| cpu_m1 | input | 1 | Opcode fetch cycle marker |
| bus_addr | output | 24 | Translated bus address |
| bus_wr | output | 1 | Write strobe, gated by rights |
| viol | output | 1 | One-cycle access violation flag |
| cur_task | output | 4 | Running task |

## Verification
The bench targets the fetch countdown. It mixes non-fetch reads into the seven fetches, places a fetch in the same cycle as the task write, and rewrites the task register partway through. A design that counts every cycle, counts one too few, or keeps counting from the old value would switch on the wrong fetch, and the eighth fetch would come out with the wrong page. It also sets the read and write rights one at a time. A design that mixes up the two bits would suppress the wrong strobe or flag the wrong access. Once a user task is running, table and task writes are issued and the translation is checked again. A design that leaks user writes would then show a changed page or a new task.

// File: rtl/taskmap_pkg.sv
package taskmap_pkg;
    localparam int TASK_W     = 4;
    localparam int SEG_W      = 4;
    localparam int OFF_W      = 12;
    localparam int PAGE_W     = 12;
    localparam int IDX_W      = TASK_W + SEG_W;
    localparam int ENTRIES    = 1 << IDX_W;
    localparam int FETCH_WAIT = 7;

    typedef struct packed {
        logic              wr_ok;
        logic              rd_ok;
        logic [PAGE_W-1:0] page;
    } map_entry_t;

    // Power-up contents: tasks 0 and 1 share the identity map,
    // task n owns the 64 KB bank n.
    function automatic map_entry_t boot_entry(input logic [IDX_W-1:0] idx);
        map_entry_t e;
        e.wr_ok = 1'b1;
        e.rd_ok = 1'b1;
        if (idx[IDX_W-1:SEG_W] < 2)
            e.page = PAGE_W'(idx[SEG_W-1:0]);
        else
            e.page = PAGE_W'(idx);
        return e;
    endfunction
endpackage

// File: rtl/taskmap_store.sv
module taskmap_store
    import taskmap_pkg::*;
#(
    parameter int N_ENTRIES = ENTRIES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sup,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  map_entry_t       wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output map_entry_t       rd_entry
);
    map_entry_t mem [N_ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENTRIES; i++)
                mem[i] <= boot_entry(IDX_W'(i));
        end else if (we && sup) begin
            mem[wr_idx] <= wr_entry;
        end
    end

    assign rd_entry = mem[rd_idx];

    // R8: a user task cannot change an entry
    a_r8_user_map_locked: assert property (@(posedge clk) disable iff (rst)
        (we && !sup) |=> (mem[$past(wr_idx)] == $past(mem[wr_idx])));
endmodule

// File: rtl/taskmap_switch.sv
module taskmap_switch
    import taskmap_pkg::*;
#(
    parameter int WAIT = FETCH_WAIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              task_we,
    input  logic [TASK_W-1:0] task_data,
    input  logic              m1,
    output logic [TASK_W-1:0] cur_task
);
    localparam int CNT_W = $clog2(WAIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT - 1);

    typedef enum logic {IDLE, ARMED} sw_state_t;

    sw_state_t         state;
    logic [CNT_W-1:0]  fetches;
    logic [TASK_W-1:0] target;
    logic              sup;

    assign sup = (cur_task == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= IDLE;
            fetches  <= '0;
            target   <= '0;
            cur_task <= '0;
        end else if (task_we && sup) begin
            state   <= ARMED;
            fetches <= '0;
            target  <= task_data;
        end else if (state == ARMED && m1) begin
            if (fetches == LAST) begin
                cur_task <= target;
                state    <= IDLE;
                fetches  <= '0;
            end else begin
                fetches <= fetches + 1'b1;
            end
        end
    end

    // R6: the running task only moves on a fetch cycle
    a_r6_switch_on_fetch: assert property (@(posedge clk) disable iff (rst)
        !m1 |=> $stable(cur_task));
    // R8: once a user task runs, it stays
    a_r8_user_keeps_task: assert property (@(posedge clk) disable iff (rst)
        (cur_task != '0) |=> $stable(cur_task));
    // R7: an accepted task write always restarts the count
    a_r7_restart_count: assert property (@(posedge clk) disable iff (rst)
        (task_we && sup) |=> (fetches == '0 && state == ARMED));
endmodule

// File: rtl/taskmap_guard.sv
module taskmap_guard
    import taskmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  map_entry_t entry,
    input  logic       cpu_rd,
    input  logic       cpu_wr,
    output logic       bus_wr,
    output logic       viol
);
    logic denied;

    assign denied = (cpu_rd && !entry.rd_ok) || (cpu_wr && !entry.wr_ok);
    assign bus_wr = cpu_wr && entry.wr_ok;

    always_ff @(posedge clk) begin
        if (rst) viol <= 1'b0;
        else     viol <= denied;
    end

    // R4: no strobe without a CPU write
    a_r4_strobe_needs_cpu: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> cpu_wr);
    // R5: a flag always traces back to an access
    a_r5_flag_after_access: assert property (@(posedge clk) disable iff (rst)
        viol |-> $past(cpu_rd || cpu_wr));
endmodule

// File: rtl/taskmap_mmu.sv
module taskmap_mmu
    import taskmap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        map_we,
    input  logic [7:0]  map_idx,
    input  logic [15:0] map_data,
    input  logic        task_we,
    input  logic [3:0]  task_data,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic        cpu_m1,
    output logic [23:0] bus_addr,
    output logic        bus_wr,
    output logic        viol,
    output logic [3:0]  cur_task
);
    map_entry_t       wr_entry, rd_entry;
    logic [IDX_W-1:0] look_idx;
    logic             sup;

    assign sup      = (cur_task == '0);
    assign wr_entry = map_entry_t'(map_data[PAGE_W+1:0]);
    assign look_idx = {cur_task, cpu_addr[OFF_W+SEG_W-1:OFF_W]};

    taskmap_store u_store (
        .clk(clk), .rst(rst), .sup(sup), .we(map_we), .wr_idx(map_idx),
        .wr_entry(wr_entry), .rd_idx(look_idx), .rd_entry(rd_entry)
    );

    taskmap_switch u_switch (
        .clk(clk), .rst(rst), .task_we(task_we), .task_data(task_data),
        .m1(cpu_m1), .cur_task(cur_task)
    );

    taskmap_guard u_guard (
        .clk(clk), .rst(rst), .entry(rd_entry), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .bus_wr(bus_wr), .viol(viol)
    );

    assign bus_addr = {rd_entry.page, cpu_addr[OFF_W-1:0]};
endmodule

// File: tb/taskmap_mmu_test.sv
module taskmap_mmu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        map_we = 1'b0;
    logic [7:0]  map_idx = '0;
    logic [15:0] map_data = '0;
    logic        task_we = 1'b0;
    logic [3:0]  task_data = '0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_m1 = 1'b0;
    logic [23:0] bus_addr;
    logic        bus_wr, viol;
    logic [3:0]  cur_task;

    int errors = 0;
    int checks = 0;

    // reference model state
    int m_map [256];
    int m_task, m_target, m_count;
    bit m_armed, m_viol;

    always #10 clk = ~clk;

    taskmap_mmu uut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++)
            m_map[i] = 32'h3000 | (((i >> 4) < 2) ? (i & 15) : i);
        m_task = 0; m_armed = 0; m_count = 0; m_target = 0; m_viol = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; map_we = 0; task_we = 0; cpu_rd = 0; cpu_wr = 0; cpu_m1 = 0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        #2;
        check(cur_task == 0, "R1 task", cur_task, 0);
        check(viol == 0, "R1 viol", viol, 0);
    endtask

    // one bus cycle: drive, compare against the model, advance the model
    task automatic cyc(input bit mwe, input int midx, input int mdat,
                       input bit twe, input int tdat,
                       input int a, input bit rd, input bit wr, input bit m1);
        int ent, exp_addr;
        bit exp_wr, next_viol;
        @(negedge clk);
        map_we = mwe; map_idx = 8'(midx); map_data = 16'(mdat);
        task_we = twe; task_data = 4'(tdat);
        cpu_addr = 16'(a); cpu_rd = rd; cpu_wr = wr; cpu_m1 = m1;
        #2;
        ent = m_map[(m_task << 4) | ((a >> 12) & 15)];
        exp_addr = ((ent & 32'hfff) << 12) | (a & 32'hfff);
        exp_wr = wr && ((ent >> 13) & 1);
        check(bus_addr == 24'(exp_addr), "R2 bus_addr", bus_addr, exp_addr);
        check(bus_wr == exp_wr, "R4 bus_wr", bus_wr, exp_wr);
        check(viol == m_viol, "R5 viol", viol, m_viol);
        check(cur_task == 4'(m_task), "R6 cur_task", cur_task, m_task);
        next_viol = (rd && !((ent >> 12) & 1)) || (wr && !((ent >> 13) & 1));
        @(posedge clk);
        m_viol = next_viol;
        if (mwe && m_task == 0) m_map[midx & 255] = mdat & 32'h3fff;
        if (twe && m_task == 0) begin
            m_armed = 1; m_count = 0; m_target = tdat;
        end else if (m_armed && m1) begin
            m_count++;
            if (m_count == 7) begin
                m_task = m_target; m_armed = 0;
            end
        end
    endtask

    task automatic fetch(input int a); cyc(0, 0, 0, 0, 0, a, 1, 0, 1); endtask
    task automatic rdc(input int a);   cyc(0, 0, 0, 0, 0, a, 1, 0, 0); endtask
    task automatic wrc(input int a);   cyc(0, 0, 0, 0, 0, a, 0, 1, 0); endtask

    initial begin
        #4ms;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 R2: identity map for task 0 across all segments
        for (int s = 0; s < 16; s++) fetch((s << 12) | 12'h5a5);
        // R3: rewrite entry 3 and read through it
        cyc(1, 8'h03, 16'hcabc, 0, 0, 0, 0, 0, 0);   // bits 15:14 ignored
        rdc(16'h3123);
        check(bus_addr == 24'habc123, "R3 new page", bus_addr, 24'habc123);
        // R4 R5: no rights, read-only, write-only
        cyc(1, 8'h04, 16'h0111, 0, 0, 0, 0, 0, 0);
        rdc(16'h4000); wrc(16'h4001);
        cyc(1, 8'h04, 16'h1111, 0, 0, 0, 0, 0, 0);
        wrc(16'h4002); rdc(16'h4003);
        cyc(1, 8'h04, 16'h2111, 0, 0, 0, 0, 0, 0);
        rdc(16'h4004); wrc(16'h4005); fetch(16'h0000);
        // R6 R9: arm task 5 in a fetch cycle, mix non-fetch cycles
        cyc(0, 0, 0, 1, 5, 16'h0010, 1, 0, 1);
        for (int i = 0; i < 3; i++) fetch(16'h0011 + i);
        rdc(16'h0020); wrc(16'h0021);
        for (int i = 0; i < 3; i++) fetch(16'h0014 + i);
        check(cur_task == 0, "R6 still supervisor after 6", cur_task, 0);
        fetch(16'h0017);                              // 7th fetch, still task 0
        fetch(16'h2222);                              // 8th fetch in task 5
        check(bus_addr == 24'h052222, "R6 eighth fetch in new task", bus_addr, 24'h052222);
        // R8: user task cannot write map or task
        cyc(1, 8'h50, 16'h3777, 1, 2, 16'h0000, 1, 0, 1);
        for (int i = 0; i < 10; i++) fetch(16'h0100 + i);
        check(bus_addr == 24'h050109, "R8 map unchanged", bus_addr, 24'h050109);
        check(cur_task == 5, "R8 task unchanged", cur_task, 5);

        // R7: restart by a second task write, then land in task 1
        do_reset();
        cyc(0, 0, 0, 1, 9, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) fetch(i);
        cyc(0, 0, 0, 1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) fetch(i);
        check(cur_task == 0, "R7 restarted count", cur_task, 0);
        fetch(16'h0006);
        fetch(16'hf321);
        check(cur_task == 1, "R7 new target used", cur_task, 1);
        check(bus_addr == 24'h00f321, "R1 task 1 identity", bus_addr, 24'h00f321);
        wrc(16'h8000); rdc(16'h8001); fetch(16'h8002);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule